// File: doc/BRIEF.md
# Quadratic Tanh Activation Unit

This unit turns a signed fixed-point accumulator value into a tanh-shaped activation without any lookup table. The input is an 8-bit two's complement number with 4 fractional bits (Q3.4). The output is an 8-bit two's complement number with 6 fractional bits (Q1.6), so +1.0 is 64 (0x40) and -1.0 is -64 (0xC0).

The curve is built from a second-order polynomial. Beyond a saturation level of 2.0 the output is clamped to plus or minus one. Inside that range the unit evaluates n·(β − θn) with β = 1 and θ = 1/4. It works on the magnitude of the input and then restores the sign, so the curve is an exact mirror image about zero. With these constants the quadratic term becomes a square followed by a shift, and the linear term is a plain left shift.

A combinational region decoder places each input in one of four named regions: RG_SAT_HI, RG_SAT_LO, RG_POLY_POS or RG_POLY_NEG. A single output register gives one cycle of latency, and the valid flag travels through the register alongside the data. There are no states and no transitions: the only sequential element is that output register.

Top module: `tanh_q_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and out_act is 0.
- R2: out_valid equals in_valid delayed by one clock. When in_valid is 1, out_act carries the result for that in_acc after the next rising edge.
- R3: If the signed value of in_acc is 32 or more (n ≥ 2.0), out_act is 64 (+1.0 in Q1.6).
- R4: If the signed value of in_acc is -32 or less (n ≤ -2.0), out_act is -64 (0xC0).
- R5: For in_acc x with 0 ≤ x < 32, out_act = 4x − floor(x²/16). This is 64·(n − n²/4) with the quadratic term truncated.
- R6: For -32 < x < 0, out_act = −(4|x| − floor(x²/16)), so that f(−x) = −f(x) for every |x| < 128.
- R7: While in_valid is 0, out_act keeps its previous value.
- R8: The signed value of out_act never leaves the range −64 to +64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_acc holds a value to convert |
| in_acc | input | 8 | Accumulator value, two's complement, Q3.4 |
| out_valid | output | 1 | out_act was updated by the last edge |
| out_act | output | 8 | Activation, two's complement, Q1.6 |

## Verification
The hardest cases are the edges of the polynomial region. At x = 31 the truncated square must still give exactly 64. At x = 32 and x = −32 the unit must switch to saturation. At x = −128 the magnitude does not fit the signed range and would wrap if the decoder relied on it. A plain ramp of input values seldom lands on these points, so the bench sweeps all 256 input codes back to back and stores each result. It then compares every pair x, −x to confirm the mirror symmetry, and drops in_valid while changing in_acc to show that the held output is not disturbed.

// File: rtl/tanh_q_pkg.sv
package tanh_q_pkg;

    // Where an input lands on the piecewise curve
    typedef enum logic [1:0] {
        RG_SAT_HI   = 2'd0,
        RG_SAT_LO   = 2'd1,
        RG_POLY_POS = 2'd2,
        RG_POLY_NEG = 2'd3
    } region_e;

endpackage

// File: rtl/tanh_q_region.sv
module tanh_q_region
    import tanh_q_pkg::*;
#(
    parameter int IN_W    = 8,
    parameter int IN_FRAC = 4,
    parameter int SAT_INT = 2
) (
    input  logic [IN_W-1:0] x,
    output region_e         region,
    output logic [IN_W-1:0] mag
);
    localparam int SAT_LSB = SAT_INT << IN_FRAC;
    localparam logic signed [IN_W:0] SAT_P = (IN_W+1)'(SAT_LSB);
    localparam logic signed [IN_W:0] SAT_N = -SAT_P;

    logic signed [IN_W:0] x_ext;

    always_comb begin
        x_ext = {x[IN_W-1], x};
        if (x_ext >= SAT_P) begin
            region = RG_SAT_HI;
        end else if (x_ext <= SAT_N) begin
            region = RG_SAT_LO;
        end else if (x[IN_W-1]) begin
            region = RG_POLY_NEG;
        end else begin
            region = RG_POLY_POS;
        end
        mag = x[IN_W-1] ? (~x + 1'b1) : x;
    end
endmodule

// File: rtl/tanh_q_poly.sv
module tanh_q_poly #(
    parameter int IN_W        = 8,
    parameter int IN_FRAC     = 4,
    parameter int OUT_W       = 8,
    parameter int OUT_FRAC    = 6,
    parameter int THETA_SHIFT = 2
) (
    input  logic [IN_W-1:0]  mag,
    output logic [OUT_W-1:0] val
);
    localparam int WI     = 2*IN_W + 2;
    localparam int SH_LIN = OUT_FRAC - IN_FRAC;
    localparam int SH_SQ  = 2*IN_FRAC - OUT_FRAC + THETA_SHIFT;

    logic [WI-1:0] lin;
    logic [WI-1:0] sq;
    logic [WI-1:0] diff;

    // m*(1 - m/4) in output LSBs: linear term by shift, quadratic by square and shift
    always_comb begin
        lin  = WI'(mag) << SH_LIN;
        sq   = WI'(mag) * WI'(mag);
        diff = lin - (sq >> SH_SQ);
        val  = diff[OUT_W-1:0];
    end
endmodule

// File: rtl/tanh_q_unit.sv
module tanh_q_unit
    import tanh_q_pkg::*;
#(
    parameter int IN_W        = 8,
    parameter int IN_FRAC     = 4,
    parameter int OUT_W       = 8,
    parameter int OUT_FRAC    = 6,
    parameter int SAT_INT     = 2,
    parameter int THETA_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_acc,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_act
);
    localparam logic [OUT_W-1:0] ONE_Q  = OUT_W'(1) << OUT_FRAC;
    localparam logic [OUT_W-1:0] MONE_Q = ~ONE_Q + 1'b1;

    region_e          region;
    logic [IN_W-1:0]  mag;
    logic [OUT_W-1:0] poly_val;
    logic [OUT_W-1:0] act_nxt;

    tanh_q_region #(
        .IN_W(IN_W), .IN_FRAC(IN_FRAC), .SAT_INT(SAT_INT)
    ) u_region (
        .x(in_acc), .region(region), .mag(mag)
    );

    tanh_q_poly #(
        .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W),
        .OUT_FRAC(OUT_FRAC), .THETA_SHIFT(THETA_SHIFT)
    ) u_poly (
        .mag(mag), .val(poly_val)
    );

    always_comb begin
        unique case (region)
            RG_SAT_HI:   act_nxt = ONE_Q;
            RG_SAT_LO:   act_nxt = MONE_Q;
            RG_POLY_POS: act_nxt = poly_val;
            RG_POLY_NEG: act_nxt = ~poly_val + 1'b1;
            default:     act_nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_act   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_act <= act_nxt;
            end
        end
    end
endmodule

// File: rtl/tanh_q_unit_chk.sv
module tanh_q_unit_chk #(
    parameter int IN_W     = 8,
    parameter int IN_FRAC  = 4,
    parameter int OUT_W    = 8,
    parameter int OUT_FRAC = 6,
    parameter int SAT_INT  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_acc,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_act
);
    localparam logic signed [IN_W:0]  SAT_P = (IN_W+1)'(SAT_INT << IN_FRAC);
    localparam logic signed [IN_W:0]  SAT_N = -SAT_P;
    localparam logic signed [OUT_W-1:0] ONE_S  = OUT_W'(1) << OUT_FRAC;
    localparam logic signed [OUT_W-1:0] MONE_S = -ONE_S;

    logic signed [IN_W:0] acc_ext;
    assign acc_ext = {in_acc[IN_W-1], in_acc};

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_act));
    p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_ext >= SAT_P) |=> (out_act == ONE_S));
    p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_ext <= SAT_N) |=> (out_act == MONE_S));
    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(out_act) <= ONE_S) && ($signed(out_act) >= MONE_S));
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_acc == '0) |=> (out_act == '0));
endmodule

bind tanh_q_unit tanh_q_unit_chk #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W),
    .OUT_FRAC(OUT_FRAC), .SAT_INT(SAT_INT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
    .out_valid(out_valid), .out_act(out_act)
);

// File: tb/tanh_q_unit_tb.sv
module tanh_q_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_acc = '0;
    logic       out_valid;
    logic [7:0] out_act;

    int total = 0;
    int bad = 0;
    int res [256];
    bit done = 0;

    always #10 clk = ~clk;

    tanh_q_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
        .out_valid(out_valid), .out_act(out_act)
    );

    function automatic int ref_act(int x);
        int m;
        int v;
        if (x >= 32) return 64;
        if (x <= -32) return -64;
        m = (x < 0) ? -x : x;
        v = 4*m - (m*m)/16;
        return (x < 0) ? -v : v;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string req_of(int x);
        if (x >= 32) return "R3";
        if (x <= -32) return "R4";
        if (x >= 0) return "R5";
        return "R6";
    endfunction

    initial begin
        // R1: reset state
        #35;
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 act in reset", int'($signed(out_act)), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 act after reset", int'($signed(out_act)), 0);

        // Exhaustive sweep, back to back; R2 latency checked on every step
        for (int i = 0; i < 256; i++) begin
            in_valid = 1'b1;
            in_acc   = 8'(i);
            @(negedge clk);
            check("R2 valid follows", int'(out_valid), 1);
            res[i] = int'($signed(out_act));
            check(req_of(int'($signed(8'(i)))), res[i], ref_act(int'($signed(8'(i)))));
        end

        // R6: mirror symmetry on stored results
        for (int x = 1; x < 128; x++) begin
            check("R6 symmetry", res[x], -res[256 - x]);
        end

        // R8: range over all results
        for (int i = 0; i < 256; i++) begin
            check("R8 range", int'((res[i] <= 64) && (res[i] >= -64)), 1);
        end

        // Boundary spot checks
        in_valid = 1'b1; in_acc = 8'd31;  @(negedge clk);
        check("R5 x=31", int'($signed(out_act)), 64);
        in_acc = 8'd32; @(negedge clk);
        check("R3 x=32", int'($signed(out_act)), 64);
        in_acc = 8'hE0; @(negedge clk);
        check("R4 x=-32", int'($signed(out_act)), -64);
        in_acc = 8'h80; @(negedge clk);
        check("R4 x=-128", int'($signed(out_act)), -64);
        in_acc = 8'd8; @(negedge clk);
        check("R5 x=8", int'($signed(out_act)), 28);

        // R7: hold while in_valid is low, input changes meanwhile
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            in_acc = 8'(8'h70 - 8'(k * 40));
            @(negedge clk);
            check("R2 valid low", int'(out_valid), 0);
            check("R7 hold", int'($signed(out_act)), 28);
        end
        in_valid = 1'b1; in_acc = 8'hF0; @(negedge clk);
        check("R6 x=-16", int'($signed(out_act)), -48);
        in_valid = 1'b0; @(negedge clk);
        check("R2 valid drop", int'(out_valid), 0);
        check("R7 hold neg", int'($signed(out_act)), -48);

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule